// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six arithmetic status flags of an integer add or subtract at a chosen operand width of 8, 16 or 32 bits. It sees the two operands and the result that the datapath already computed, together with the operation and the width. From these it works out the carry or borrow at each point of interest and registers the flag vector when a write strobe is high.

Carries are not taken from the adder. The carry into any bit position is recovered as the XOR of that bit of A, B and the result. That one value gives the auxiliary carry at bit 4 and the carry into the top bit at the selected width. From the carry into the top bit, the carry or borrow out of it follows.

Control is a plain strobe with no back-pressure. Each cycle with `flag_we` high loads a new flag vector, and the block cannot stall the datapath. Inputs are sampled at the rising clock edge. The new flags appear on `flags_q` right after that edge.

Top module: `asf_flag_unit`

## Requirements
- R1: With `op_sub`=0, flag bit 0 (carry) is 1 exactly when the unsigned sum of A and B at the selected width does not fit in that width.
- R2: With `op_sub`=1, flag bit 0 (carry) is 1 exactly when A is less than B as unsigned values at the selected width (a borrow out of the top bit).
- R3: Flag bit 5 (overflow) is 1 exactly when the signed result at the selected width is out of range. This is the carry into the top bit XOR the carry out of it.
- R4: Flag bit 3 (zero) is 1 exactly when the result bits below the selected width are all 0. Result bits above the width have no effect.
- R5: Flag bit 4 (sign) equals the result bit at position width-1.
- R6: Flag bit 1 (parity) is 1 when result bits [7:0] hold an even number of ones, whatever the width.
- R7: Flag bit 2 (auxiliary) is 1 when a carry (add) or borrow (sub) passes from bit 3 into bit 4.
- R8: While `flag_we` is 0, `flags_q` keeps its value whatever the other inputs do.
- R9: An active-low `rst_n` clears all six flags to 0.
- R10: `size_sel` codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Code 3 behaves as 32 bits.
- R11: Flags computed from the inputs sampled at a rising edge with `flag_we`=1 are on `flags_q` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (subtrahend for sub) |
| result | input | 32 | Result produced by the datapath |
| op_sub | input | 1 | 0 add, 1 subtract |
| size_sel | input | 2 | Operand width code |
| flag_we | input | 1 | Flag register write strobe |
| flags_q | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
Random operands almost never produce the narrow-width corner cases. These cases are a zero result with live junk bits above the width, a signed boundary crossing at 16 bits, and a borrow out of bit 3 while the upper bytes cancel. Directed vectors therefore hit each boundary at every width. The random phase also fills the unused upper operand and result bits with noise, which exposes any leak from outside the selected width. Write-disabled cycles are mixed in at random, and the bench model tracks the held value.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int NSIZES = 3;
  localparam int FLAG_N = 6;
  localparam int NIB_W  = BYTE_W / 2;

  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_B16  = 2'd1,
    SZ_B32  = 2'd2,
    SZ_RSVD = 2'd3
  } asf_size_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } asf_flags_t;
endpackage

// File: rtl/asf_size_view.sv
module asf_size_view
  import asf_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic [1:0]        size_sel,
  output logic              top_a,
  output logic              top_b,
  output logic              top_r,
  output logic              zero
);
  logic [NSIZES-1:0] ta_v, tb_v, tr_v, z_v;
  logic [1:0]        idx;

  for (genvar g = 0; g < NSIZES; g++) begin : g_lane
    localparam int W = BYTE_W << g;
    assign ta_v[g] = a[W-1];
    assign tb_v[g] = b[W-1];
    assign tr_v[g] = r[W-1];
    assign z_v[g]  = ~|r[W-1:0];
  end

  always_comb begin
    idx = (asf_size_e'(size_sel) == SZ_RSVD) ? 2'(SZ_B32) : size_sel;
    top_a = ta_v[idx];
    top_b = tb_v[idx];
    top_r = tr_v[idx];
    zero  = z_v[idx];
  end
endmodule

// File: rtl/asf_carry_probe.sv
module asf_carry_probe (
  input  logic sub,
  input  logic top_a,
  input  logic top_b,
  input  logic top_r,
  input  logic a4,
  input  logic b4,
  input  logic r4,
  output logic cry,
  output logic ovf,
  output logic aux
);
  logic cin_top, cout_top;

  always_comb begin
    cin_top  = top_a ^ top_b ^ top_r;
    if (sub) cout_top = (~top_a & top_b) | (cin_top & ~(top_a ^ top_b));
    else     cout_top = (top_a & top_b) | (cin_top & (top_a ^ top_b));
    cry = cout_top;
    ovf = cin_top ^ cout_top;
    aux = a4 ^ b4 ^ r4;
  end

  // R3: overflow agrees with the sign-pattern rule
  always_comb begin
    a_r3_ovf_sign_rule: assert (ovf == (sub ? ((top_a != top_b) && (top_r != top_a))
                                            : ((top_a == top_b) && (top_r != top_a))))
      else $error("overflow disagrees with sign rule");
  end
endmodule

// File: rtl/asf_parity.sv
module asf_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         even
);
  logic [W:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_x
    assign chain[i+1] = chain[i] ^ bits[i];
  end
  assign even = chain[W];

  // R6: parity reflects an even count of ones
  always_comb begin
    a_r6_even_ones: assert (even == ($countones(bits) % 2 == 0))
      else $error("parity mismatch");
  end
endmodule

// File: rtl/asf_flag_unit.sv
module asf_flag_unit
  import asf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              op_sub,
  input  logic [1:0]        size_sel,
  input  logic              flag_we,
  output logic [FLAG_N-1:0] flags_q
);
  logic       top_a, top_b, top_r, zero;
  logic       cry, ovf, aux, par;
  asf_flags_t nxt, cur;

  asf_size_view u_view (
    .a(opnd_a), .b(opnd_b), .r(result), .size_sel(size_sel),
    .top_a(top_a), .top_b(top_b), .top_r(top_r), .zero(zero)
  );

  asf_carry_probe u_probe (
    .sub(op_sub), .top_a(top_a), .top_b(top_b), .top_r(top_r),
    .a4(opnd_a[NIB_W]), .b4(opnd_b[NIB_W]), .r4(result[NIB_W]),
    .cry(cry), .ovf(ovf), .aux(aux)
  );

  asf_parity #(.W(BYTE_W)) u_par (
    .bits(result[BYTE_W-1:0]), .even(par)
  );

  always_comb begin
    nxt.ovf = ovf;
    nxt.sgn = top_r;
    nxt.zro = zero;
    nxt.aux = aux;
    nxt.par = par;
    nxt.cry = cry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (flag_we) cur <= nxt;
  end

  assign flags_q = cur;

  logic [BYTE_W:0] chk_sum8, chk_dif8;
  assign chk_sum8 = {1'b0, opnd_a[BYTE_W-1:0]} + {1'b0, opnd_b[BYTE_W-1:0]};
  assign chk_dif8 = {1'b0, opnd_a[BYTE_W-1:0]} - {1'b0, opnd_b[BYTE_W-1:0]};

  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));
  // R4 / R5
  a_r4_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> !(flags_q[3] && flags_q[4]));
  // R1
  a_r1_byte_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !op_sub && size_sel == 2'd0 && result[BYTE_W-1:0] == chk_sum8[BYTE_W-1:0])
    |=> flags_q[0] == $past(chk_sum8[BYTE_W]));
  // R2
  a_r2_byte_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sub && size_sel == 2'd0 && result[BYTE_W-1:0] == chk_dif8[BYTE_W-1:0])
    |=> flags_q[0] == $past(chk_dif8[BYTE_W]));
endmodule

// File: tb/asf_flag_unit_bench.sv
module asf_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, result = '0;
  logic        op_sub = 1'b0, flag_we = 1'b0;
  logic [1:0]  size_sel = '0;
  logic [5:0]  flags_q;
  logic [5:0]  exp_flags = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  asf_flag_unit u_asf_flag_unit (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .op_sub(op_sub), .size_sel(size_sel), .flag_we(flag_we), .flags_q(flags_q)
  );

  function automatic int width_of(logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] ref_result(logic [31:0] a, logic [31:0] b,
                                             logic [1:0] sz, logic sub);
    longint unsigned m;
    m = (64'd1 << width_of(sz)) - 1;
    return sub ? 32'(((a & m) - (b & m)) & m) : 32'(((a & m) + (b & m)) & m);
  endfunction

  function automatic logic [5:0] ref_flags(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] r_in, logic [1:0] sz, logic sub);
    int n;
    longint unsigned m, ua, ub, r, full;
    logic cf, of, af, zf, sf, pf;
    n = width_of(sz);
    m = (64'd1 << n) - 1;
    ua = a & m; ub = b & m; r = r_in & m;
    if (!sub) begin
      full = ua + ub;
      cf = full[n];
      of = (ua[n-1] == ub[n-1]) && (r[n-1] != ua[n-1]);
      af = ((ua & 15) + (ub & 15)) > 15;
    end else begin
      cf = ua < ub;
      of = (ua[n-1] != ub[n-1]) && (r[n-1] != ua[n-1]);
      af = (ua & 15) < (ub & 15);
    end
    zf = (r == 0);
    sf = r[n-1];
    pf = ($countones(r[7:0]) % 2) == 0;
    return {of, sf, zf, af, pf, cf};
  endfunction

  task automatic check(string req);
    n_chk++;
    if (flags_q !== exp_flags) begin
      n_fail++;
      $display("FAIL %s: flags actual %b expected %b", req, flags_q, exp_flags);
    end
  endtask

  // drive at negedge, latch at posedge, compare at next negedge
  task automatic step(logic [31:0] a, logic [31:0] b, logic [31:0] junk,
                      logic [1:0] sz, logic sub, logic we, string req);
    logic [31:0] r, m32;
    m32 = (width_of(sz) == 32) ? 32'hFFFF_FFFF : ((32'd1 << width_of(sz)) - 1);
    r = ref_result(a, b, sz, sub) | (junk & ~m32);
    opnd_a = a; opnd_b = b; result = r; size_sel = sz; op_sub = sub; flag_we = we;
    if (we) exp_flags = ref_flags(a, b, r, sz, sub);
    @(negedge clk);
    check(req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset clears");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release");
    // directed corners
    step(32'h7F, 32'h01, 32'h0, 2'd0, 1'b0, 1'b1, "R3 byte signed overflow add");
    step(32'hFF, 32'h01, 32'hABCD_1200, 2'd0, 1'b0, 1'b1, "R1 R4 byte wrap zero junk");
    step(32'h0000_FFFF, 32'h1, 32'h0, 2'd1, 1'b0, 1'b1, "R1 half carry");
    step(32'h0, 32'h1, 32'h0, 2'd2, 1'b1, 1'b1, "R2 R5 word borrow");
    step(32'h8000, 32'h1, 32'hFFFF_0000, 2'd1, 1'b1, 1'b1, "R3 half signed overflow sub");
    step(32'h0F, 32'h01, 32'h0, 2'd0, 1'b0, 1'b1, "R7 aux carry");
    step(32'h1_0010, 32'h1, 32'h0, 2'd2, 1'b1, 1'b1, "R7 aux borrow");
    step(32'h0300, 32'h0, 32'h0, 2'd1, 1'b0, 1'b1, "R6 parity low byte only");
    step(32'h8000_0000, 32'h8000_0000, 32'h0, 2'd3, 1'b0, 1'b1, "R10 code 3 as word");
    step(32'h1234_5678, 32'h1, 32'h0, 2'd0, 1'b1, 1'b0, "R8 hold");
    step(32'h0, 32'h0, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b0, "R8 hold");
    step(32'h0, 32'h0, 32'h0, 2'd2, 1'b0, 1'b1, "R4 R11 zero word");
    // random sweep over every width code
    for (int sz = 0; sz < 4; sz++) begin
      for (int i = 0; i < 400; i++) begin
        step($urandom, $urandom, $urandom, 2'(sz), 1'($urandom),
             ($urandom % 4) != 0, "R1 R2 R3 R4 R5 R6 R7 R8 R11 random");
      end
    end
    done = 1;
    summary();
  end
endmodule